// File: doc/BRIEF.md
# T1 Framing-Bit Loss-of-Frame Monitor

This block watches the framing bit of every received T1 frame once the receiver has locked. On each frame strobe it compares the received framing bit with the bit the framing pattern predicts at that position. It records whether the two disagreed in a short history of recent frames. When two disagreements fall inside the configured window of recent framing bits, it declares loss of frame.

Two select inputs set the window length to 4, 5 or 6 framing bits. A criteria input decides what triggers a resync request. The request can follow loss of frame alone, or loss of frame together with a receive-carrier-loss indication. The request is a one-cycle pulse. The frame synchronizer that sits before this block reports each new lock. That report clears the history and returns the monitor to the in-frame state.

Top module: `t1_fbit_oof_mon`

## Requirements
- R1: After reset, `oof` is 1 and `resync_req` is 0.
- R2: A cycle with `lock_new` = 1 makes `oof` 0 on the next cycle and empties the history, so disagreements seen before the lock never count toward a later loss of frame. `lock_new` takes priority over a strobe in the same cycle.
- R3: With `win_sel_a` = 0 and `win_sel_b` = 0, a strobe that leaves 2 or more disagreements among the 4 most recent framing bits (this bit included) sets `oof` 1 on the next cycle. A disagreement means `fbit_rx` differs from `fbit_exp`.
- R4: With `win_sel_a` = 1 and `win_sel_b` = 0, the window is the 5 most recent framing bits.
- R5: With `win_sel_b` = 1, the window is the 6 most recent framing bits, whatever the value of `win_sel_a`.
- R6: Disagreements that lie further back than the configured window do not set `oof`.
- R7: Cycles without `frm_stb` leave the history and `oof` unchanged. This holds even when `fbit_rx` and `fbit_exp` differ. Strobes that arrive while `oof` is 1 are not recorded, and `oof` stays 1 until the next `lock_new`.
- R8: With `resync_only_oof` = 1, `resync_req` pulses only when `oof` rises, one cycle after the rise. `carrier_loss` has no effect.
- R9: With `resync_only_oof` = 0, `resync_req` also pulses when `carrier_loss` rises while `oof` is 0. The pulse comes one cycle after the cycle in which `carrier_loss` is first high.
- R10: `resync_req` is high for exactly one cycle for each rising edge of the qualifying condition, even when that condition stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_stb | input | 1 | One-cycle strobe at the framing-bit position of each frame |
| fbit_rx | input | 1 | Received framing bit, valid with `frm_stb` |
| fbit_exp | input | 1 | Framing bit expected by the pattern, valid with `frm_stb` |
| lock_new | input | 1 | Synchronizer reports a fresh frame lock |
| win_sel_a | input | 1 | Window select: 1 widens the window from 4 to 5 bits |
| win_sel_b | input | 1 | Window select: 1 forces a 6-bit window |
| resync_only_oof | input | 1 | 1: resync on loss of frame only; 0: also on carrier loss |
| carrier_loss | input | 1 | Receive-carrier-loss indication |
| oof | output | 1 | Out-of-frame flag |
| resync_req | output | 1 | One-cycle resync request pulse |

## Verification
A strobe or lock sampled at a rising edge shows its effect on `oof` right after that same edge. A resync pulse caused by a new `oof` value appears one edge later, so it lands two edges after the strobe. A carrier-loss rise needs only the single edge of the pulse register. The bench drives every cycle at the falling edge and pushes one expected (`oof`, `resync_req`) pair into a queue for each driven cycle. A monitor pops one item 1 ns after each following rising edge. The two-edge resync latency is covered by the model's own record of the previous cycle's condition, not by a shift in sampling time.

// File: rtl/t1fm_pkg.sv
`timescale 1ns/1ps
package t1fm_pkg;

  // Window choice decoded from the two select pins; the wide choice dominates.
  typedef enum logic [1:0] {
    WIN_NARROW = 2'd0,
    WIN_MID    = 2'd1,
    WIN_WIDE   = 2'd2
  } win_sel_e;

  function automatic win_sel_e pick_window(input logic sel_a, input logic sel_b);
    if (sel_b)      return WIN_WIDE;
    else if (sel_a) return WIN_MID;
    else            return WIN_NARROW;
  endfunction

  // Number of framing bits added on top of the base window length.
  function automatic logic [1:0] window_extra(input win_sel_e w);
    case (w)
      WIN_MID:  return 2'd1;
      WIN_WIDE: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

  // Whether carrier loss may trigger a resync under the chosen criteria.
  function automatic logic carrier_qualifies(input logic only_oof, input logic cl);
    return ~only_oof & cl;
  endfunction

endpackage

// File: rtl/fbm_history.sv
`timescale 1ns/1ps
module fbm_history #(
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] hist_next
);
  // Only DEPTH-1 past entries are stored; the newest entry is the live input.
  logic [DEPTH-2:0] hist_q;

  assign hist_next = {hist_q, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist_q <= '0;
    else if (clr)   hist_q <= '0;
    else if (shift) hist_q <= hist_next[DEPTH-2:0];
  end
endmodule

// File: rtl/fbm_window_count.sv
`timescale 1ns/1ps
module fbm_window_count #(
  parameter int DEPTH = 6,
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [DEPTH-1:0] hist_in,
  input  logic [LEN_W-1:0] win_len,
  output logic [CNT_W-1:0] err_count
);
  logic [DEPTH-1:0] in_win;

  // Bit 0 is the newest comparison; entry i lies inside the window when i < win_len.
  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    assign in_win[i] = hist_in[i] & (LEN_W'(i) < win_len);
  end

  always_comb begin
    err_count = '0;
    for (int k = 0; k < DEPTH; k++) begin
      err_count = err_count + CNT_W'(in_win[k]);
    end
  end
endmodule

// File: rtl/fbm_resync_gen.sv
`timescale 1ns/1ps
module fbm_resync_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic pulse
);
  logic cond_d;

  // cond_d resets high: the monitor leaves reset out of frame, which must not pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_d <= 1'b1;
      pulse  <= 1'b0;
    end else begin
      cond_d <= cond;
      pulse  <= cond & ~cond_d;
    end
  end
endmodule

// File: rtl/t1_fbit_oof_mon.sv
`timescale 1ns/1ps
module t1_fbit_oof_mon #(
  parameter int WIN_BASE  = 4,
  parameter int ERR_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_stb,
  input  logic fbit_rx,
  input  logic fbit_exp,
  input  logic lock_new,
  input  logic win_sel_a,
  input  logic win_sel_b,
  input  logic resync_only_oof,
  input  logic carrier_loss,
  output logic oof,
  output logic resync_req
);
  import t1fm_pkg::*;

  localparam int HIST_W = WIN_BASE + 2;
  localparam int LEN_W  = $clog2(HIST_W + 1);
  localparam int CNT_W  = $clog2(HIST_W + 1);

  logic              oof_q;
  logic              err_bit;
  logic              take_bit;
  logic              win_trip;
  logic              resync_cond;
  logic [HIST_W-1:0] hist_next;
  logic [LEN_W-1:0]  win_len;
  logic [CNT_W-1:0]  err_count;
  win_sel_e          win_mode;

  // Named internal events, also used by the bound checker.
  assign err_bit  = fbit_rx ^ fbit_exp;
  assign take_bit = frm_stb & ~oof_q & ~lock_new;
  assign win_mode = pick_window(win_sel_a, win_sel_b);
  assign win_len  = LEN_W'(WIN_BASE) + LEN_W'(window_extra(win_mode));

  fbm_history #(.DEPTH(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (lock_new),
    .shift     (take_bit),
    .din       (err_bit),
    .hist_next (hist_next)
  );

  fbm_window_count #(.DEPTH(HIST_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_count (
    .hist_in   (hist_next),
    .win_len   (win_len),
    .err_count (err_count)
  );

  assign win_trip = (err_count >= CNT_W'(ERR_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    oof_q <= 1'b1;
    else if (lock_new)             oof_q <= 1'b0;
    else if (take_bit && win_trip) oof_q <= 1'b1;
  end

  assign resync_cond = oof_q | carrier_qualifies(resync_only_oof, carrier_loss);

  fbm_resync_gen u_resync (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (resync_cond),
    .pulse (resync_req)
  );

  assign oof = oof_q;
endmodule

// File: rtl/t1_fbit_oof_chk.sv
`timescale 1ns/1ps
module t1_fbit_oof_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_stb,
  input logic lock_new,
  input logic resync_only_oof,
  input logic take_bit,
  input logic win_trip,
  input logic oof,
  input logic resync_req
);
  assert_lock_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_new |=> !oof);

  assert_trip_sets_oof_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && win_trip) |=> oof);

  assert_no_trip_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && !win_trip) |=> !oof);

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_stb && !lock_new) |=> $stable(oof));

  assert_oof_only_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_req && $past(resync_only_oof)) |-> $past(oof));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);
endmodule

bind t1_fbit_oof_mon t1_fbit_oof_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frm_stb         (frm_stb),
  .lock_new        (lock_new),
  .resync_only_oof (resync_only_oof),
  .take_bit        (take_bit),
  .win_trip        (win_trip),
  .oof             (oof),
  .resync_req      (resync_req)
);

// File: tb/test_t1_fbit_oof_mon.sv
`timescale 1ns/1ps
module test_t1_fbit_oof_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_stb = 1'b0, fbit_rx = 1'b0, fbit_exp = 1'b0, lock_new = 1'b0;
  logic win_sel_a = 1'b0, win_sel_b = 1'b0, resync_only_oof = 1'b1, carrier_loss = 1'b0;
  logic oof, resync_req;

  always #2 clk = ~clk;

  t1_fbit_oof_mon i_t1_fbit_oof_mon (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .fbit_rx(fbit_rx),
    .fbit_exp(fbit_exp), .lock_new(lock_new), .win_sel_a(win_sel_a),
    .win_sel_b(win_sel_b), .resync_only_oof(resync_only_oof),
    .carrier_loss(carrier_loss), .oof(oof), .resync_req(resync_req)
  );

  typedef struct { bit e_oof; bit e_rs; string tag; } exp_t;
  exp_t sb[$];

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // Configuration the driver applies at each falling edge.
  bit c_a = 0, c_b = 0, c_crit = 1;

  // Independent reference state.
  bit m_hist[6];
  bit m_oof = 1'b1;
  bit m_cprev = 1'b1;

  task automatic step(input bit stb, input bit mis, input bit lock, input bit cl, input string tag);
    int len, n;
    bit cond, ers;
    exp_t it;
    @(negedge clk);
    frm_stb = stb; fbit_exp = 1'b0; fbit_rx = mis; lock_new = lock; carrier_loss = cl;
    win_sel_a = c_a; win_sel_b = c_b; resync_only_oof = c_crit;
    len = c_b ? 6 : (c_a ? 5 : 4);
    cond = m_oof || (!c_crit && cl);
    ers = cond && !m_cprev;
    m_cprev = cond;
    if (lock) begin
      foreach (m_hist[k]) m_hist[k] = 1'b0;
      m_oof = 1'b0;
    end else if (stb && !m_oof) begin
      for (int k = 5; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = mis;
      n = 0;
      for (int k = 0; k < len; k++) if (m_hist[k]) n++;
      if (n >= 2) m_oof = 1'b1;
    end
    it.e_oof = m_oof; it.e_rs = ers; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(1'b0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  // Monitor: one expected item per driven cycle, sampled after the next rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (oof !== e.e_oof || resync_req !== e.e_rs) begin
        miscompares++;
        $display("FAIL %s: oof=%0b resync_req=%0b expected oof=%0b resync_req=%0b",
                 e.tag, oof, resync_req, e.e_oof, e.e_rs);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    vectors++;  // R1 reset state
    if (oof !== 1'b1 || resync_req !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: oof=%0b resync_req=%0b expected oof=1 resync_req=0", oof, resync_req);
    end

    // R2 lock, then R3/R6/R7 with a 4-bit window
    c_a = 0; c_b = 0; c_crit = 1;
    step(0, 0, 1, 0, "R2 lock");
    step(1, 1, 0, 0, "R6 first error");
    idle(2, "R7 no strobe");
    step(1, 0, 0, 0, "R6"); step(1, 0, 0, 0, "R6"); step(1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, "R6 error outside window");
    step(1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, "R3 two in four");
    step(0, 0, 0, 0, "R8 pulse on oof rise");
    step(0, 0, 0, 0, "R10 pulse ends");
    step(1, 0, 0, 0, "R7 strobe while oof");
    step(1, 0, 0, 0, "R7 strobe while oof");

    // R2 history clear across lock
    step(0, 0, 1, 0, "R2 relock");
    step(1, 1, 0, 0, "R2");
    step(0, 0, 1, 0, "R2 lock clears history");
    step(1, 1, 0, 0, "R2 old error forgotten");
    step(1, 1, 1, 0, "R2 lock beats strobe");
    step(1, 1, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");

    // R4: 5-bit window
    c_a = 1; c_b = 0;
    step(0, 0, 1, 0, "R4 lock");
    step(1, 1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R4");
    step(1, 1, 0, 0, "R4 two in five");
    idle(2, "R4 settle");
    step(0, 0, 1, 0, "R4 lock");
    step(1, 1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, "R6 six apart in 5 window");
    idle(2, "R6 settle");

    // R5: 6-bit window, sel_b overrides sel_a, and sel_b alone
    c_a = 1; c_b = 1;
    step(0, 0, 1, 0, "R5 lock");
    step(1, 1, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R5");
    step(1, 1, 0, 0, "R5 two in six");
    idle(2, "R5 settle");
    c_a = 0; c_b = 1;
    step(0, 0, 1, 0, "R5 lock");
    step(1, 1, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R5");
    step(1, 1, 0, 0, "R5 sel_b alone");
    idle(2, "R5 settle");

    // R8: carrier loss ignored with criteria set
    c_a = 0; c_b = 0; c_crit = 1;
    step(0, 0, 1, 0, "R8 lock");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R8 carrier ignored");
    step(0, 0, 0, 0, "R8");

    // R9/R10: carrier loss triggers once with criteria clear
    c_crit = 0;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R9 R10 carrier held");
    step(0, 0, 0, 0, "R9 carrier drop");
    step(0, 0, 0, 1, "R9 carrier again");
    step(0, 0, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");
    step(1, 1, 0, 0, "R9 oof under criteria 0");
    idle(3, "R9 R10 settle");

    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule